// File: doc/BRIEF.md
# Bit-Serial Register Access Slave

This block is the device end of a four-wire serial register bus. The host uses an active-low clear line, a strobe, a data-in line and a data-out line, all toggled slowly by software. A fast system clock oversamples them. Each transaction opens with a clear pulse. An 8-bit command follows, and then a 16-bit data phase. In that phase the slave either shifts a register value out or captures a new value.

Behind the bus sits a small register file. It holds a read-only identity word and a read-only firmware-version word. It also holds a parameterised number of function-enable words and of GPIO enable and direction words, one pair per bank. The writable words drive parallel outputs that feed the pin-control logic elsewhere on the chip. An enable input gates the whole interface.

Top module: `bsr_slave`

## Requirements
- R1: After reset, every function-enable, GPIO-enable and GPIO-direction output reads 0 and data-out is low.
- R2: While the synchronised clear is low, the frame engine returns to the start of the command phase with its bit count at zero. A transaction that is cut short is discarded. A clear that arrives in the same system cycle as a strobe rising edge wins, and that edge is not counted.
- R3: The command is 8 bits, most significant bit first, sampled from data-in on each strobe rising edge. Bit 7 = 1 requests a read, bit 7 = 0 requests a write, and bits 6..0 are the register address.
- R4: In a read, data-out shows bit 15 of the addressed word as soon as the command completes. It moves to the next lower bit on each data-phase strobe rising edge after the first, so a host sampling after every falling edge receives bits 15 down to 0.
- R5: In a write, 16 data bits are captured most significant first on strobe rising edges. The addressed register changes only when the 16th bit is captured.
- R6: Address 0x00 is read-only and reads 0x0001: manufacturer code 0x01 in bits 7:0, zero above.
- R7: Address 0x01 is read-only and reads build in bits 15:12, major in 11:8 (always 0), minor in 7:4 and patch in 3:0. The defaults give 0x3025.
- R8: Function-enable word i sits at address 0x08+i for i < NUM_FUNC. GPIO-enable word b sits at 0x10+b and GPIO-direction word b at 0x18+b for b < NUM_BANK. All of them can be read and written. Word i appears on bits [16i+15:16i] of its parallel output.
- R9: Reads of any other address return 0x0000, and writes to it change no output.
- R10: Once a data phase is complete, further strobe edges are ignored until the next clear. Data-out stays low and no register changes.
- R11: While enable is low, data-out is low and no register changes. A clear is needed to start a transaction after enable returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Interface enable |
| clr_ni | input | 1 | Host clear, active low, asynchronous to clk_i |
| stb_i | input | 1 | Host strobe, asynchronous to clk_i |
| sdi_i | input | 1 | Serial data from host |
| sdo_o | output | 1 | Serial data to host |
| func_en_o | output | 16*NUM_FUNC | Function-enable words |
| gpio_en_o | output | 16*NUM_BANK | GPIO enable words |
| gpio_dir_o | output | 16*NUM_BANK | GPIO direction words |

## Verification
A clear can land in the same system cycle as a strobe rising edge. If that edge is the 16th bit of a write, the commit and the abort compete. The bench provokes this by raising strobe and dropping clear at the same instant. Both signals pass through identical synchroniser depths, so they reach the engine together. It then judges the outcome at the ports: the function-enable output must still hold its old value, and a later read of that address must return it.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned CNT_W  = 5;

  localparam logic [ADDR_W-1:0] A_PID  = 7'h00;
  localparam logic [ADDR_W-1:0] A_FWID = 7'h01;
  localparam logic [ADDR_W-1:0] A_FUNC = 7'h08;
  localparam logic [ADDR_W-1:0] A_GEN  = 7'h10;
  localparam logic [ADDR_W-1:0] A_GDIR = 7'h18;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_CMD  = 3'd1,
    PH_RD   = 3'd2,
    PH_WR   = 3'd3,
    PH_DONE = 3'd4
  } phase_e;
endpackage

// File: rtl/bsr_sync.sv
module bsr_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] ff;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff <= {2{RST_VAL[i]}};
      else         ff <= {ff[0], d_i[i]};
    end
    assign q_o[i] = ff[1];
  end
endmodule

// File: rtl/bsr_frame.sv
module bsr_frame
  import bsr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              clr_ni,
  input  logic              stb_i,
  input  logic              sdi_i,
  input  logic [WORD_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wr_stb_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [WORD_W-1:0] wr_data_o,
  output logic              sdo_o,
  output phase_e            phase_o,
  output logic [CNT_W-1:0]  cnt_o
);
  phase_e            phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] sh_q;
  logic              stb_q;
  logic              rise;
  logic [ADDR_W:0]   cmd_full;

  assign rise      = stb_i & ~stb_q;
  assign cmd_full  = {cmd_q, sdi_i};
  assign rd_addr_o = cmd_full[ADDR_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stb_q <= 1'b0;
    else         stb_q <= stb_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      cmd_q   <= '0;
      addr_q  <= '0;
      sh_q    <= '0;
    end else if (!en_i) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (!clr_ni) begin
      phase_q <= PH_CMD;
      cnt_q   <= '0;
    end else if (rise) begin
      unique case (phase_q)
        PH_CMD: begin
          cmd_q <= cmd_full[ADDR_W-1:0];
          if (cnt_q == CNT_W'(7)) begin
            addr_q <= cmd_full[ADDR_W-1:0];
            cnt_q  <= '0;
            if (cmd_full[ADDR_W]) begin
              phase_q <= PH_RD;
              sh_q    <= rd_data_i;
            end else begin
              phase_q <= PH_WR;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_RD: begin
          if (cnt_q == CNT_W'(WORD_W)) begin
            phase_q <= PH_DONE;
          end else begin
            if (cnt_q != '0) sh_q <= {sh_q[WORD_W-2:0], 1'b0};
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_WR: begin
          sh_q <= {sh_q[WORD_W-2:0], sdi_i};
          if (cnt_q == CNT_W'(WORD_W-1)) phase_q <= PH_DONE;
          else                           cnt_q   <= cnt_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign wr_stb_o  = en_i & clr_ni & rise & (phase_q == PH_WR) & (cnt_q == CNT_W'(WORD_W-1));
  assign wr_addr_o = addr_q;
  assign wr_data_o = {sh_q[WORD_W-2:0], sdi_i};
  assign sdo_o     = en_i & (phase_q == PH_RD) & sh_q[WORD_W-1];
  assign phase_o   = phase_q;
  assign cnt_o     = cnt_q;
endmodule

// File: rtl/bsr_regfile.sv
module bsr_regfile
  import bsr_pkg::*;
#(
  parameter int unsigned NUM_FUNC = 2,
  parameter int unsigned NUM_BANK = 3,
  parameter logic [7:0]  MFR_CODE = 8'h01,
  parameter logic [3:0]  FW_BUILD = 4'h3,
  parameter logic [3:0]  FW_MINOR = 4'h2,
  parameter logic [3:0]  FW_PATCH = 4'h5
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [ADDR_W-1:0]          rd_addr_i,
  output logic [WORD_W-1:0]          rd_data_o,
  input  logic                       wr_stb_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [WORD_W-1:0]          wr_data_i,
  output logic [NUM_FUNC*WORD_W-1:0] func_en_o,
  output logic [NUM_BANK*WORD_W-1:0] gpio_en_o,
  output logic [NUM_BANK*WORD_W-1:0] gpio_dir_o
);
  localparam logic [WORD_W-1:0] PID_VAL  = {8'h00, MFR_CODE};
  localparam logic [WORD_W-1:0] FWID_VAL = {FW_BUILD, 4'h0, FW_MINOR, FW_PATCH};

  for (genvar i = 0; i < NUM_FUNC; i++) begin : g_func
    logic [WORD_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else if (wr_stb_i && wr_addr_i == A_FUNC + ADDR_W'(i)) q <= wr_data_i;
    end
    assign func_en_o[i*WORD_W +: WORD_W] = q;
  end

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    logic [WORD_W-1:0] en_q, dir_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q  <= '0;
        dir_q <= '0;
      end else if (wr_stb_i) begin
        if (wr_addr_i == A_GEN  + ADDR_W'(b)) en_q  <= wr_data_i;
        if (wr_addr_i == A_GDIR + ADDR_W'(b)) dir_q <= wr_data_i;
      end
    end
    assign gpio_en_o[b*WORD_W +: WORD_W]  = en_q;
    assign gpio_dir_o[b*WORD_W +: WORD_W] = dir_q;
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == A_PID)  rd_data_o = PID_VAL;
    if (rd_addr_i == A_FWID) rd_data_o = FWID_VAL;
    for (int i = 0; i < NUM_FUNC; i++)
      if (rd_addr_i == A_FUNC + ADDR_W'(i)) rd_data_o = func_en_o[i*WORD_W +: WORD_W];
    for (int b = 0; b < NUM_BANK; b++) begin
      if (rd_addr_i == A_GEN  + ADDR_W'(b)) rd_data_o = gpio_en_o[b*WORD_W +: WORD_W];
      if (rd_addr_i == A_GDIR + ADDR_W'(b)) rd_data_o = gpio_dir_o[b*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/bsr_slave.sv
module bsr_slave
  import bsr_pkg::*;
#(
  parameter int unsigned NUM_FUNC = 2,
  parameter int unsigned NUM_BANK = 3,
  parameter logic [7:0]  MFR_CODE = 8'h01,
  parameter logic [3:0]  FW_BUILD = 4'h3,
  parameter logic [3:0]  FW_MINOR = 4'h2,
  parameter logic [3:0]  FW_PATCH = 4'h5
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       en_i,
  input  logic                       clr_ni,
  input  logic                       stb_i,
  input  logic                       sdi_i,
  output logic                       sdo_o,
  output logic [NUM_FUNC*WORD_W-1:0] func_en_o,
  output logic [NUM_BANK*WORD_W-1:0] gpio_en_o,
  output logic [NUM_BANK*WORD_W-1:0] gpio_dir_o
);
  logic              clr_s, stb_s, sdi_s;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [WORD_W-1:0] rd_data, wr_data;
  logic              wr_stb;
  phase_e            phase;
  logic [CNT_W-1:0]  cnt;

  bsr_sync #(.W(3), .RST_VAL(3'b001)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sdi_i, stb_i, clr_ni}),
    .q_o    ({sdi_s, stb_s, clr_s})
  );

  bsr_frame u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .clr_ni    (clr_s),
    .stb_i     (stb_s),
    .sdi_i     (sdi_s),
    .rd_data_i (rd_data),
    .rd_addr_o (rd_addr),
    .wr_stb_o  (wr_stb),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data),
    .sdo_o     (sdo_o),
    .phase_o   (phase),
    .cnt_o     (cnt)
  );

  bsr_regfile #(
    .NUM_FUNC (NUM_FUNC),
    .NUM_BANK (NUM_BANK),
    .MFR_CODE (MFR_CODE),
    .FW_BUILD (FW_BUILD),
    .FW_MINOR (FW_MINOR),
    .FW_PATCH (FW_PATCH)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_addr_i  (rd_addr),
    .rd_data_o  (rd_data),
    .wr_stb_i   (wr_stb),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .func_en_o  (func_en_o),
    .gpio_en_o  (gpio_en_o),
    .gpio_dir_o (gpio_dir_o)
  );
endmodule

// File: rtl/bsr_slave_chk.sv
module bsr_slave_chk
  import bsr_pkg::*;
#(
  parameter int unsigned NUM_FUNC = 2,
  parameter int unsigned NUM_BANK = 3
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       en_i,
  input logic                       sdo_o,
  input logic                       clr_s,
  input phase_e                     phase,
  input logic [CNT_W-1:0]           cnt,
  input logic                       wr_stb,
  input logic [NUM_FUNC*WORD_W-1:0] func_en_o,
  input logic [NUM_BANK*WORD_W-1:0] gpio_en_o,
  input logic [NUM_BANK*WORD_W-1:0] gpio_dir_o
);
  assert_clear_restarts_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_s) |=> (phase == PH_CMD && cnt == '0));

  assert_cnt_bounded_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CNT_W'(WORD_W));

  assert_regs_hold_without_commit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_stb |=> ($stable(func_en_o) && $stable(gpio_en_o) && $stable(gpio_dir_o)));

  assert_sdo_quiet_after_frame_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase != PH_RD) |-> !sdo_o);

  assert_disabled_no_change_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(func_en_o) && $stable(gpio_en_o) && $stable(gpio_dir_o)));

  assert_disabled_sdo_low_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !sdo_o);
endmodule

bind bsr_slave bsr_slave_chk #(.NUM_FUNC(NUM_FUNC), .NUM_BANK(NUM_BANK)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .sdo_o      (sdo_o),
  .clr_s      (clr_s),
  .phase      (phase),
  .cnt        (cnt),
  .wr_stb     (wr_stb),
  .func_en_o  (func_en_o),
  .gpio_en_o  (gpio_en_o),
  .gpio_dir_o (gpio_dir_o)
);

// File: tb/bsr_slave_tb.sv
module bsr_slave_tb;
  localparam int NF = 2;
  localparam int NB = 3;
  localparam int HP = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1, clr_n = 1'b1, stb = 1'b0, sdi = 1'b0;
  logic sdo;
  logic [NF*16-1:0] func_en;
  logic [NB*16-1:0] gpio_en, gpio_dir;

  int checks = 0, failures = 0;
  bit finished = 0;

  logic [15:0] exp_q[$];
  logic [15:0] obs_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  bsr_slave #(.NUM_FUNC(NF), .NUM_BANK(NB)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .clr_ni(clr_n), .stb_i(stb),
    .sdi_i(sdi), .sdo_o(sdo), .func_en_o(func_en), .gpio_en_o(gpio_en),
    .gpio_dir_o(gpio_dir)
  );

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start();
    clr_n = 1'b0; wt(HP);
    clr_n = 1'b1; wt(HP);
  endtask

  task automatic send_cmd(input logic [7:0] c);
    for (int i = 7; i >= 0; i--) begin
      stb = 1'b0; sdi = c[i]; wt(HP);
      stb = 1'b1; wt(HP);
    end
    stb = 1'b0; wt(HP);
  endtask

  task automatic shift_out(output logic [15:0] w);
    for (int i = 15; i >= 0; i--) begin
      stb = 1'b1; wt(HP);
      stb = 1'b0; wt(HP);
      w[i] = sdo;
    end
    stb = 1'b1; wt(HP);
  endtask

  task automatic shift_in(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) begin
      sdi = w[i]; wt(HP);
      stb = 1'b1; wt(HP);
      stb = 1'b0; wt(HP);
    end
    stb = 1'b1; wt(HP);
  endtask

  // driver: pushes expectation, performs the read, pushes observation
  task automatic rd(input logic [6:0] a, input logic [15:0] exp, input string tag);
    logic [15:0] w;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    start();
    send_cmd({1'b1, a});
    shift_out(w);
    obs_q.push_back(w);
  endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    start();
    send_cmd({1'b0, a});
    shift_in(d);
  endtask

  // monitor
  initial begin
    forever begin
      wait (obs_q.size() > 0);
      begin
        logic [15:0] o, e;
        string t;
        o = obs_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(o === e, t, o, e);
      end
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    wt(5);
    rst_n = 1'b1;
    wt(5);
    // R1 reset state
    check(func_en === '0, "R1 func_en", func_en[15:0], 16'h0);
    check(gpio_en === '0 && gpio_dir === '0, "R1 gpio", gpio_en[15:0], 16'h0);
    check(sdo === 1'b0, "R1 sdo", {15'h0, sdo}, 16'h0);

    // R6 R7 identity words
    rd(7'h00, 16'h0001, "R6 platform id");
    rd(7'h01, 16'h3025, "R7 firmware id");

    // R4: bit 15 visible right after command
    start();
    send_cmd(8'h81);
    check(sdo === 1'b0, "R4 first bit of 0x3025", {15'h0, sdo}, 16'h0);
    shift_out(w);
    check(w === 16'h3025, "R4 full word", w, 16'h3025);

    // R8 R3 R5 writable map
    wr(7'h08, 16'hA5C3);
    check(func_en[15:0] === 16'hA5C3, "R5 func0 out", func_en[15:0], 16'hA5C3);
    wr(7'h09, 16'h8001);
    check(func_en[31:16] === 16'h8001, "R8 func1 out", func_en[31:16], 16'h8001);
    wr(7'h12, 16'h1234);
    check(gpio_en[47:32] === 16'h1234, "R8 gpio_en2 out", gpio_en[47:32], 16'h1234);
    wr(7'h18, 16'hFFFF);
    check(gpio_dir[15:0] === 16'hFFFF, "R8 gpio_dir0 out", gpio_dir[15:0], 16'hFFFF);
    rd(7'h08, 16'hA5C3, "R3 read func0");
    rd(7'h12, 16'h1234, "R8 read gpio_en2");
    rd(7'h18, 16'hFFFF, "R8 read gpio_dir0");

    // R6 R7 read-only
    wr(7'h00, 16'hFFFF);
    rd(7'h00, 16'h0001, "R6 write ignored");
    wr(7'h01, 16'h0F00);
    rd(7'h01, 16'h3025, "R7 write ignored");

    // R9 unmapped
    wr(7'h0A, 16'h5555);
    wr(7'h1B, 16'h5555);
    check(func_en === {16'h8001, 16'hA5C3}, "R9 func unchanged", func_en[15:0], 16'hA5C3);
    check(gpio_dir === {32'h0, 16'hFFFF}, "R9 dir unchanged", gpio_dir[31:16], 16'h0);
    rd(7'h0A, 16'h0000, "R9 unmapped read");
    rd(7'h7F, 16'h0000, "R9 top address read");

    // R2 partial command then restart
    start();
    for (int i = 0; i < 4; i++) begin
      stb = 1'b0; sdi = 1'b0; wt(HP);
      stb = 1'b1; wt(HP);
    end
    rd(7'h09, 16'h8001, "R2 aborted command discarded");

    // R2/R5 partial write aborted: 10 bits then clear
    start();
    send_cmd(8'h10);
    for (int i = 0; i < 10; i++) begin
      sdi = 1'b1; wt(HP); stb = 1'b1; wt(HP); stb = 1'b0; wt(HP);
    end
    check(gpio_en[15:0] === 16'h0, "R5 partial write no change", gpio_en[15:0], 16'h0);
    rd(7'h10, 16'h0000, "R2 partial write discarded");

    // R2 clear coincident with 16th rising edge
    start();
    send_cmd(8'h08);
    for (int i = 15; i >= 1; i--) begin
      sdi = 1'b0; wt(HP); stb = 1'b1; wt(HP); stb = 1'b0; wt(HP);
    end
    sdi = 1'b0; wt(HP);
    stb = 1'b1; clr_n = 1'b0; wt(HP);
    clr_n = 1'b1; stb = 1'b0; wt(HP);
    check(func_en[15:0] === 16'hA5C3, "R2 clear beats commit", func_en[15:0], 16'hA5C3);
    rd(7'h08, 16'hA5C3, "R2 clear beats commit readback");

    // R10 extra strobes after write
    wr(7'h11, 16'h00F0);
    shift_in(16'hFFFF);
    check(gpio_en[31:16] === 16'h00F0, "R10 extra write strobes ignored", gpio_en[31:16], 16'h00F0);
    // R10 extra strobes after read
    start();
    send_cmd(8'h80);
    shift_out(w);
    shift_out(w);
    check(w === 16'h0000, "R10 sdo quiet after read", w, 16'h0000);

    // R11 enable low
    en = 1'b0;
    wr(7'h19, 16'hBEEF);
    check(gpio_dir[31:16] === 16'h0, "R11 no write while disabled", gpio_dir[31:16], 16'h0);
    start();
    send_cmd(8'h81);
    shift_out(w);
    check(w === 16'h0000, "R11 sdo low while disabled", w, 16'h0000);
    en = 1'b1;
    wt(HP);
    rd(7'h19, 16'h0000, "R11 register untouched");
    wr(7'h19, 16'hBEEF);
    rd(7'h19, 16'hBEEF, "R11 works after re-enable");

    wait (obs_q.size() == 0);
    wt(4);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule